// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sequences the low-power states of a small processor system. Software issues a one-cycle request with a mode code. In Idle the block stops only the CPU clock and leaves the peripherals clocked. In Sleep it stops the CPU clock and the peripheral clock, turns off the main oscillator and holds the fail-safe clock monitor inactive. It keeps the low-power RC clock running in Sleep only when the watchdog is enabled. When it accepts a Sleep request with the watchdog enabled, it issues a watchdog clear.

The controller runs on a free-running low-power clock. It therefore sees wake conditions even while the system clock is stopped. Three things wake the system: an interrupt that is both pending and individually enabled, a watchdog time-out, or a reset. Leaving Idle is immediate. Leaving Sleep first turns the oscillator back on, then keeps the CPU clock gated for a programmable restart count. The block also records the clock-source selection that was active before a low-power state and presents it unchanged on wake-up.

Top module: `pmc_power_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the block reports mode 2'b00 (Run). CPU, peripheral and oscillator enables are 1, the saved clock selection equals the reset default (0), and the wake pulse is 0.
- R2: A request with code 2'b01, accepted in Run, gives mode 2'b01 (Idle) in the next cycle. In Idle the CPU clock enable is 0, and the peripheral clock enable and oscillator enable stay 1.
- R3: A request with code 2'b10, accepted in Run, gives mode 2'b10 (Sleep) in the next cycle. In Sleep the CPU clock enable, peripheral clock enable and oscillator enable are all 0.
- R4: The watchdog clear output is 1 only in the cycle in which a Sleep request is accepted, and only when the watchdog is enabled. An Idle request never produces a clear.
- R5: In Sleep the low-power RC enable equals the watchdog enable input. In every other mode it is 1.
- R6: The wake sources are a pending interrupt whose enable bit is set, and the watchdog time-out. A pending interrupt whose enable bit is clear does not wake the block, and no wake source has any effect in Run.
- R7: A wake source present in Idle returns the block to Run in the next cycle. In that first Run cycle the CPU clock enable is 1 and the wake pulse is 1, and the pulse lasts exactly one cycle.
- R8: A wake source present in Sleep gives mode 2'b11 (restart) in the next cycle, with the oscillator enable at 1 and the CPU clock enable at 0. The restart state lasts restart_cnt+1 cycles. The block then enters Run with a one-cycle wake pulse.
- R9: In Run, the saved clock selection output follows the clock-selection input one cycle later. Outside Run the output holds its value, so after wake-up it shows the selection that was active at entry.
- R10: Requests are ignored outside Run, and requests with code 2'b00 or 2'b11 are ignored in every mode.
- R11: Asserting reset in Sleep forces Run immediately and returns the saved clock selection to its default.
- R12: The fail-safe monitor enable equals its configuration input in Run and Idle, and is 0 in Sleep and restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-power clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle power-mode request strobe |
| req_mode | input | 2 | Requested mode code (01 Idle, 10 Sleep) |
| irq_pend | input | N_IRQ | Pending interrupt flags |
| irq_en | input | N_IRQ | Per-interrupt wake enables |
| wdt_timeout | input | 1 | Watchdog time-out event |
| wdt_enable | input | 1 | Watchdog enabled |
| fscm_cfg | input | 1 | Fail-safe monitor configured on |
| clk_sel_in | input | CSEL_W | Currently selected clock source |
| restart_cnt | input | RESTART_W | Oscillator restart hold count |
| mode_o | output | 2 | Current mode (00 Run, 01 Idle, 10 Sleep, 11 restart) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| lprc_en | output | 1 | Low-power RC clock enable |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| wdt_clr | output | 1 | Watchdog clear strobe |
| wake_pulse | output | 1 | One-cycle wake indication on return to Run |
| clk_sel_out | output | CSEL_W | Saved clock-source selection |

## Verification
The hardest case to reach is the clock-selection restore. The selection input must change while the block sits in Sleep, a wake must arrive, and the output must still show the entry value through the whole restart window. The stimulus sets one selection in Run and enters Sleep. It then changes the selection and sends a stray Idle request and a masked interrupt, none of which may wake the block. Finally it enables the interrupt, counts the restart cycles one by one, and checks the saved selection in the first Run cycle and again one cycle later.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      PM_RUN   = 2'b00,
      PM_IDLE  = 2'b01,
      PM_SLEEP = 2'b10,
      PM_WAKE  = 2'b11
   } pm_state_t;

   localparam logic [1:0] REQ_IDLE  = 2'b01;
   localparam logic [1:0] REQ_SLEEP = 2'b10;
endpackage

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
   parameter int N_IRQ     = 8,
   parameter int WAKE_SYNC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_pend,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             wdt_timeout,
   output logic             wake
);
   logic raw_wake;
   assign raw_wake = (|(irq_pend & irq_en)) | wdt_timeout;

   generate
      if (WAKE_SYNC == 0) begin : g_direct
         assign wake = raw_wake;
      end else begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], raw_wake};
         end
         assign wake = sync_q[1];
      end
   endgenerate
endmodule

// File: rtl/pmc_restart_timer.sv
module pmc_restart_timer #(
   parameter int RESTART_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [RESTART_W-1:0] load_val,
   output logic                 done
);
   logic [RESTART_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
   import pmc_pkg::*;
#(
   parameter int          CSEL_W   = 3,
   parameter logic [CSEL_W-1:0] CSEL_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_mode,
   input  logic              wake,
   input  logic              restart_done,
   input  logic [CSEL_W-1:0] clk_sel_in,
   output pm_state_t         state,
   output logic              sleep_accept,
   output logic              timer_load,
   output logic              wake_pulse,
   output logic [CSEL_W-1:0] clk_sel_saved
);
   pm_state_t state_d;
   logic      idle_accept;
   logic      pulse_d;

   assign sleep_accept = (state == PM_RUN) && req_valid && (req_mode == REQ_SLEEP);
   assign idle_accept  = (state == PM_RUN) && req_valid && (req_mode == REQ_IDLE);
   assign timer_load   = (state == PM_SLEEP) && wake;

   always_comb begin
      state_d = state;
      pulse_d = 1'b0;
      unique case (state)
         PM_RUN: begin
            if (sleep_accept)     state_d = PM_SLEEP;
            else if (idle_accept) state_d = PM_IDLE;
         end
         PM_IDLE: begin
            if (wake) begin
               state_d = PM_RUN;
               pulse_d = 1'b1;
            end
         end
         PM_SLEEP: begin
            if (wake) state_d = PM_WAKE;
         end
         PM_WAKE: begin
            if (restart_done) begin
               state_d = PM_RUN;
               pulse_d = 1'b1;
            end
         end
         default: state_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= PM_RUN;
         wake_pulse    <= 1'b0;
         clk_sel_saved <= CSEL_RST;
      end else begin
         state      <= state_d;
         wake_pulse <= pulse_d;
         if (state == PM_RUN) clk_sel_saved <= clk_sel_in;
      end
   end
endmodule

// File: rtl/pmc_power_mode_ctrl.sv
module pmc_power_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int                N_IRQ     = 8,
   parameter int                CSEL_W    = 3,
   parameter logic [CSEL_W-1:0] CSEL_RST  = '0,
   parameter int                RESTART_W = 8,
   parameter int                WAKE_SYNC = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           req_mode,
   input  logic [N_IRQ-1:0]     irq_pend,
   input  logic [N_IRQ-1:0]     irq_en,
   input  logic                 wdt_timeout,
   input  logic                 wdt_enable,
   input  logic                 fscm_cfg,
   input  logic [CSEL_W-1:0]    clk_sel_in,
   input  logic [RESTART_W-1:0] restart_cnt,
   output logic [1:0]           mode_o,
   output logic                 cpu_clk_en,
   output logic                 per_clk_en,
   output logic                 osc_en,
   output logic                 lprc_en,
   output logic                 fscm_en,
   output logic                 wdt_clr,
   output logic                 wake_pulse,
   output logic [CSEL_W-1:0]    clk_sel_out
);
   generate
      if (N_IRQ < 1)                          begin : g_bad_irq   $error("N_IRQ must be at least 1"); end
      if (CSEL_W < 1)                         begin : g_bad_csel  $error("CSEL_W must be at least 1"); end
      if (RESTART_W < 1 || RESTART_W > 32)    begin : g_bad_rst   $error("RESTART_W out of range"); end
      if (WAKE_SYNC != 0 && WAKE_SYNC != 1)   begin : g_bad_sync  $error("WAKE_SYNC must be 0 or 1"); end
   endgenerate

   pm_state_t state;
   logic      wake, restart_done, timer_load, sleep_accept;
   logic      in_active;

   pmc_wake_detect #(.N_IRQ(N_IRQ), .WAKE_SYNC(WAKE_SYNC)) u_wake (
      .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
      .wdt_timeout(wdt_timeout), .wake(wake)
   );

   pmc_restart_timer #(.RESTART_W(RESTART_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(restart_cnt),
      .done(restart_done)
   );

   pmc_seq #(.CSEL_W(CSEL_W), .CSEL_RST(CSEL_RST)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .wake(wake), .restart_done(restart_done), .clk_sel_in(clk_sel_in),
      .state(state), .sleep_accept(sleep_accept), .timer_load(timer_load),
      .wake_pulse(wake_pulse), .clk_sel_saved(clk_sel_out)
   );

   assign in_active  = (state == PM_RUN) || (state == PM_IDLE);
   assign mode_o     = state;
   assign cpu_clk_en = (state == PM_RUN);
   assign per_clk_en = in_active;
   assign osc_en     = (state != PM_SLEEP);
   assign lprc_en    = (state != PM_SLEEP) || wdt_enable;
   assign fscm_en    = fscm_cfg && in_active;
   assign wdt_clr    = sleep_accept && wdt_enable;
endmodule

// File: rtl/pmc_power_mode_chk.sv
module pmc_power_mode_chk #(
   parameter int N_IRQ     = 8,
   parameter int CSEL_W    = 3,
   parameter int RESTART_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [1:0]           req_mode,
   input logic [N_IRQ-1:0]     irq_pend,
   input logic [N_IRQ-1:0]     irq_en,
   input logic                 wdt_timeout,
   input logic                 wdt_enable,
   input logic                 fscm_cfg,
   input logic [CSEL_W-1:0]    clk_sel_in,
   input logic [RESTART_W-1:0] restart_cnt,
   input logic [1:0]           mode_o,
   input logic                 cpu_clk_en,
   input logic                 per_clk_en,
   input logic                 osc_en,
   input logic                 lprc_en,
   input logic                 fscm_en,
   input logic                 wdt_clr,
   input logic                 wake_pulse,
   input logic [CSEL_W-1:0]    clk_sel_out
);
   logic wake_any;
   assign wake_any = (|(irq_pend & irq_en)) | wdt_timeout;

   assert_idle_gating_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 2'b01 |-> !cpu_clk_en && per_clk_en && osc_en);

   assert_sleep_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 2'b10 |-> !cpu_clk_en && !per_clk_en && !osc_en);

   assert_clear_needs_wdt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |-> wdt_enable && mode_o == 2'b00 && req_valid);

   assert_lprc_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == 2'b10 |-> lprc_en == wdt_enable);

   assert_idle_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01 && wake_any) |=> mode_o == 2'b00 && wake_pulse && cpu_clk_en);

   assert_sleep_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b10 && wake_any) |=> mode_o == 2'b11 && osc_en && !cpu_clk_en);

   assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'b00 |=> $stable(clk_sel_out));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01 && !wake_any) |=> mode_o == 2'b01);

   assert_fscm_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o[1] |-> !fscm_en);

   assert_fscm_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_o[1] |-> fscm_en == fscm_cfg);

   logic unused_ok;
   assign unused_ok = ^{req_mode, restart_cnt, clk_sel_in};
endmodule

bind pmc_power_mode_ctrl pmc_power_mode_chk #(
   .N_IRQ(N_IRQ), .CSEL_W(CSEL_W), .RESTART_W(RESTART_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
   .irq_pend(irq_pend), .irq_en(irq_en), .wdt_timeout(wdt_timeout),
   .wdt_enable(wdt_enable), .fscm_cfg(fscm_cfg), .clk_sel_in(clk_sel_in),
   .restart_cnt(restart_cnt), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
   .per_clk_en(per_clk_en), .osc_en(osc_en), .lprc_en(lprc_en),
   .fscm_en(fscm_en), .wdt_clr(wdt_clr), .wake_pulse(wake_pulse),
   .clk_sel_out(clk_sel_out)
);

// File: tb/tb_pmc_power_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pmc_power_mode_ctrl;
   localparam int N_IRQ = 8, CSEL_W = 3, RESTART_W = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic req_valid;
   logic [1:0] req_mode;
   logic [N_IRQ-1:0] irq_pend, irq_en;
   logic wdt_timeout, wdt_enable, fscm_cfg;
   logic [CSEL_W-1:0] clk_sel_in;
   logic [RESTART_W-1:0] restart_cnt;
   logic [1:0] mode_o;
   logic cpu_clk_en, per_clk_en, osc_en, lprc_en, fscm_en, wdt_clr, wake_pulse;
   logic [CSEL_W-1:0] clk_sel_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pmc_power_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .irq_pend(irq_pend), .irq_en(irq_en), .wdt_timeout(wdt_timeout),
      .wdt_enable(wdt_enable), .fscm_cfg(fscm_cfg), .clk_sel_in(clk_sel_in),
      .restart_cnt(restart_cnt), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .lprc_en(lprc_en),
      .fscm_en(fscm_en), .wdt_clr(wdt_clr), .wake_pulse(wake_pulse),
      .clk_sel_out(clk_sel_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk(mode_o == 2'b00, "R1 mode", mode_o, 0);
      chk({cpu_clk_en, per_clk_en, osc_en} == 3'b111, "R1 enables", {cpu_clk_en, per_clk_en, osc_en}, 7);
      chk(clk_sel_out == 0, "R1 clk_sel_out", clk_sel_out, 0);
      chk(wake_pulse == 0, "R1 wake_pulse", wake_pulse, 0);
      rst_n = 1'b1;
      step();
      step();
      chk(mode_o == 2'b00 && wake_pulse == 0, "R1 after release", mode_o, 0);
      chk(clk_sel_out == 5, "R9 follows input in Run", clk_sel_out, 5);
   endtask

   task automatic t_sleep_wdt();
      int n;
      wdt_enable = 1'b1;
      req_valid = 1'b1; req_mode = 2'b10;
      #1;
      chk(wdt_clr == 1, "R4 clear on sleep entry", wdt_clr, 1);
      step();
      req_valid = 1'b0;
      chk(mode_o == 2'b10, "R3 mode sleep", mode_o, 2);
      chk({cpu_clk_en, per_clk_en, osc_en} == 3'b000, "R3 enables", {cpu_clk_en, per_clk_en, osc_en}, 0);
      chk(wdt_clr == 0, "R4 clear only one cycle", wdt_clr, 0);
      chk(fscm_en == 0, "R12 fscm off in sleep", fscm_en, 0);
      chk(lprc_en == 1, "R5 lprc kept with wdt", lprc_en, 1);
      clk_sel_in = 3'd1;
      req_valid = 1'b1; req_mode = 2'b01;
      step();
      req_valid = 1'b0;
      chk(mode_o == 2'b10, "R10 request ignored in sleep", mode_o, 2);
      chk(clk_sel_out == 5, "R9 held in sleep", clk_sel_out, 5);
      irq_pend = 8'h04; irq_en = 8'h00;
      step();
      chk(mode_o == 2'b10, "R6 masked irq no wake", mode_o, 2);
      irq_en = 8'h04;
      step();
      irq_pend = '0; irq_en = '0;
      chk(mode_o == 2'b11 && osc_en && !cpu_clk_en, "R8 restart entered", mode_o, 3);
      chk(fscm_en == 0, "R12 fscm off in restart", fscm_en, 0);
      n = 1;
      for (int i = 0; i < 20 && mode_o == 2'b11; i++) begin
         step();
         if (mode_o == 2'b11) n++;
      end
      chk(n == 4, "R8 restart length", n, 4);
      chk(mode_o == 2'b00 && cpu_clk_en && wake_pulse, "R8 run with pulse", mode_o, 0);
      chk(clk_sel_out == 5, "R9 restored selection", clk_sel_out, 5);
      step();
      chk(wake_pulse == 0, "R8 pulse one cycle", wake_pulse, 0);
      chk(clk_sel_out == 1, "R9 follows again", clk_sel_out, 1);
   endtask

   task automatic t_idle();
      req_valid = 1'b1; req_mode = 2'b01;
      #1;
      chk(wdt_clr == 0, "R4 no clear on idle", wdt_clr, 0);
      step();
      req_valid = 1'b0;
      chk(mode_o == 2'b01, "R2 mode idle", mode_o, 1);
      chk({cpu_clk_en, per_clk_en, osc_en} == 3'b011, "R2 enables", {cpu_clk_en, per_clk_en, osc_en}, 3);
      chk(fscm_en == 1, "R12 fscm on in idle", fscm_en, 1);
      chk(lprc_en == 1, "R5 lprc on in idle", lprc_en, 1);
      step();
      chk(mode_o == 2'b01, "R2 idle holds", mode_o, 1);
      wdt_timeout = 1'b1;
      step();
      wdt_timeout = 1'b0;
      chk(mode_o == 2'b00 && cpu_clk_en && wake_pulse, "R7 idle wake", mode_o, 0);
      step();
      chk(wake_pulse == 0, "R7 pulse one cycle", wake_pulse, 0);
   endtask

   task automatic t_sleep_nowdt();
      wdt_enable = 1'b0;
      restart_cnt = 8'd0;
      req_valid = 1'b1; req_mode = 2'b10;
      #1;
      chk(wdt_clr == 0, "R4 no clear without wdt", wdt_clr, 0);
      step();
      req_valid = 1'b0;
      chk(lprc_en == 0, "R5 lprc off without wdt", lprc_en, 0);
      irq_pend = 8'h80; irq_en = 8'h80;
      step();
      irq_pend = '0; irq_en = '0;
      chk(mode_o == 2'b11, "R8 restart zero count", mode_o, 3);
      step();
      chk(mode_o == 2'b00 && wake_pulse, "R8 one restart cycle", mode_o, 0);
      restart_cnt = 8'd3;
      wdt_enable = 1'b1;
   endtask

   task automatic t_ignore();
      req_valid = 1'b1; req_mode = 2'b00;
      step();
      chk(mode_o == 2'b00, "R10 code 00 ignored", mode_o, 0);
      req_mode = 2'b11;
      step();
      req_valid = 1'b0;
      chk(mode_o == 2'b00, "R10 code 11 ignored", mode_o, 0);
      irq_pend = 8'h01; irq_en = 8'h01; wdt_timeout = 1'b1;
      step();
      step();
      irq_pend = '0; irq_en = '0; wdt_timeout = 1'b0;
      chk(mode_o == 2'b00 && wake_pulse == 0, "R6 no effect in run", wake_pulse, 0);
   endtask

   task automatic t_reset_sleep();
      clk_sel_in = 3'd6;
      step();
      req_valid = 1'b1; req_mode = 2'b10;
      step();
      req_valid = 1'b0;
      chk(mode_o == 2'b10 && clk_sel_out == 6, "R11 in sleep saved", clk_sel_out, 6);
      rst_n = 1'b0;
      #1;
      chk(mode_o == 2'b00 && cpu_clk_en, "R11 reset forces run", mode_o, 0);
      chk(clk_sel_out == 0, "R11 selection default", clk_sel_out, 0);
      step();
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'b00;
      irq_pend = '0; irq_en = '0; wdt_timeout = 1'b0;
      wdt_enable = 1'b1; fscm_cfg = 1'b1;
      clk_sel_in = 3'd5; restart_cnt = 8'd3;
      #10;
      t_reset();
      t_sleep_wdt();
      t_idle();
      t_sleep_nowdt();
      t_ignore();
      t_reset_sleep();
      step();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule